// File: doc/BRIEF.md
# Dual-Clock FIFO with Configurable Synchronizers

This block moves data words from one clock domain to another through a small dual-port storage array. A producer in the write clock domain presents a word together with a write request. A consumer in the read clock domain raises a read request and sees the word on its output one read clock later. The two clocks may have any phase or frequency relation.

Each domain gets a full flag, an empty flag and a used-word count, all computed from its own pointer and a synchronized copy of the other domain's pointer. Both flags are therefore conservative. The producer acts on the write-side full flag and the consumer on the read-side empty flag. The block drops a write into a full FIFO and a read from an empty one.

The synchronizer length on each crossing is a parameter, and a related-clocks setting shortens it. The count outputs can carry extra pipeline delay and an optional extra most significant bit. A single asynchronous clear can have its release resynchronized separately into each domain.

Top module: `xfifo_dc`

## Requirements
- R1: Words leave `rd_data` in the order they were accepted on the write side. A read accepted at a read clock edge (`rd_req` high while `rd_empty` is low) places its word on `rd_data` at that same edge.
- R2: `wr_full` is high exactly when the write side counts `2**ADDR_W` words outstanding. A write request made while `wr_full` is high stores nothing and does not move the write pointer.
- R3: A read request made while `rd_empty` is high leaves `rd_data`, the read pointer and `rd_used` unchanged.
- R4: `wr_empty` is a delayed view of the read pointer and `rd_full` is a delayed view of the write pointer. `wr_empty` stays low for at least one write clock after the last read. `rd_full` rises within a few read clocks once the FIFO is full.
- R5: The number of flops on each crossing is the depth setting minus 2, with a minimum of 1, and is 1 when `CLOCKS_RELATED` is set. A pointer crossing a domain changes by at most one bit per clock. With the defaults (two flops), a first write clears `rd_empty` by the third read clock falling edge after the write edge.
- R6: Each used-word count sits behind `*_CNT_DLY` register stages; the default is 1. With the default, `wr_used` shows a write one write clock after the edge that accepted it. The raw count never exceeds `2**ADDR_W`.
- R7: With `COUNT_MSB` = 1, both counts are `ADDR_W+1` bits wide and a full FIFO reports `2**ADDR_W`. With 0, the counts are `ADDR_W` bits and a full FIFO wraps to 0.
- R8: Raising `clr` empties the FIFO. Afterwards both empty flags are 1, both full flags are 0, both counts are 0 and `rd_data` is 0. When resynchronization is enabled, the release of the clear takes effect on a clock edge of each domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clr | input | 1 | Asynchronous clear, active high |
| wclk | input | 1 | Write clock |
| wr_data | input | DATA_W | Word to store |
| wr_req | input | 1 | Write request |
| wr_full | output | 1 | Full, as seen from the write domain |
| wr_empty | output | 1 | Empty, as seen from the write domain |
| wr_used | output | ADDR_W+COUNT_MSB | Word count, write domain |
| rclk | input | 1 | Read clock |
| rd_req | input | 1 | Read request |
| rd_data | output | DATA_W | Word read out |
| rd_full | output | 1 | Full, as seen from the read domain |
| rd_empty | output | 1 | Empty, as seen from the read domain |
| rd_used | output | ADDR_W+COUNT_MSB | Word count, read domain |

## Verification
The write side's own results are due at fixed times. `wr_full` and `wr_empty` reflect a write at the accepting edge, `wr_used` one write clock later, and `rd_data` at the read edge that accepts the request. The bench samples each of these at the falling edge right after the cycle in which it is due. Results that cross the boundary cannot be pinned to one edge, because they depend on the phase of the other clock. For those the bench counts falling edges of the destination clock and checks a window: not yet visible at the first sample, visible by the bound that the flop count implies. Words are compared in order by a scoreboard queue whose entries are pushed only when the write was accepted.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;
  // flop count on one crossing from its depth setting
  function automatic int sync_stages(input int setting, input bit related);
    if (related) return 1;
    if (setting > 3) return setting - 2;
    return 1;
  endfunction
endpackage

// File: rtl/xfifo_rst_sync.sv
module xfifo_rst_sync #(
  parameter bit ENABLE = 1'b1,
  parameter int LEN    = 2
) (
  input  logic clk,
  input  logic clr,
  output logic rst
);
  generate
    if (ENABLE) begin : g_sync
      logic [LEN-1:0] sh;
      always_ff @(posedge clk or posedge clr) begin
        if (clr) sh <= '1;
        else     sh <= {sh[LEN-2:0], 1'b0};
      end
      assign rst = sh[LEN-1];
    end else begin : g_pass
      assign rst = clr;
    end
  endgenerate
endmodule

// File: rtl/xfifo_sync.sv
module xfifo_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] ff [STAGES];
  always_ff @(posedge clk or posedge rst) begin
    if (rst) ff[0] <= '0;
    else     ff[0] <= d;
  end
  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or posedge rst) begin
        if (rst) ff[i] <= '0;
        else     ff[i] <= ff[i-1];
      end
    end
  endgenerate
  assign q = ff[STAGES-1];
endmodule

// File: rtl/xfifo_port_ctl.sv
module xfifo_port_ctl #(
  parameter int AW       = 4,
  parameter int CW       = 5,
  parameter int CNT_DLY  = 1,
  parameter bit PRODUCER = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [AW:0]   far_gray,
  output logic [AW:0]   near_gray,
  output logic [AW-1:0] addr,
  output logic          step,
  output logic          full,
  output logic          empty,
  output logic [AW:0]   used_raw,
  output logic [CW-1:0] used
);
  logic [AW:0] near_bin, near_nx, far_bin;
  logic [AW:0] wg, rg, wb, rb;

  function automatic logic [AW:0] to_gray(input logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [AW:0] from_gray(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  assign near_nx = near_bin + (AW+1)'(1);
  assign far_bin = from_gray(far_gray);
  assign addr    = near_bin[AW-1:0];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      near_bin  <= '0;
      near_gray <= '0;
    end else if (step) begin
      near_bin  <= near_nx;
      near_gray <= to_gray(near_nx);
    end
  end

  // orient pointers as write/read regardless of which side this is
  generate
    if (PRODUCER) begin : g_wr
      assign wg = near_gray; assign rg = far_gray;
      assign wb = near_bin;  assign rb = far_bin;
      assign step = req & ~full;
    end else begin : g_rd
      assign wg = far_gray;  assign rg = near_gray;
      assign wb = far_bin;   assign rb = near_bin;
      assign step = req & ~empty;
    end
  endgenerate

  assign full     = (wg == {~rg[AW:AW-1], rg[AW-2:0]});
  assign empty    = (wg == rg);
  assign used_raw = wb - rb;

  generate
    if (CNT_DLY == 0) begin : g_nodly
      assign used = used_raw[CW-1:0];
    end else begin : g_dly
      logic [CW-1:0] pipe [CNT_DLY];
      always_ff @(posedge clk or posedge rst) begin
        if (rst) pipe[0] <= '0;
        else     pipe[0] <= used_raw[CW-1:0];
      end
      for (genvar i = 1; i < CNT_DLY; i++) begin : g_p
        always_ff @(posedge clk or posedge rst) begin
          if (rst) pipe[i] <= '0;
          else     pipe[i] <= pipe[i-1];
        end
      end
      assign used = pipe[CNT_DLY-1];
    end
  endgenerate
endmodule

// File: rtl/xfifo_ram.sv
module xfifo_ram #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk or posedge rrst) begin
    if (rrst)    rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/xfifo_dc.sv
module xfifo_dc #(
  parameter int DATA_W         = 8,
  parameter int ADDR_W         = 4,
  parameter int WR2RD_SYNC     = 4,
  parameter int RD2WR_SYNC     = 4,
  parameter bit CLOCKS_RELATED = 1'b0,
  parameter int WR_CNT_DLY     = 1,
  parameter int RD_CNT_DLY     = 1,
  parameter bit COUNT_MSB      = 1'b1,
  parameter bit WR_CLR_SYNC    = 1'b1,
  parameter bit RD_CLR_SYNC    = 1'b1
) (
  input  logic                        clr,
  input  logic                        wclk,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic                        wr_req,
  output logic                        wr_full,
  output logic                        wr_empty,
  output logic [ADDR_W+COUNT_MSB-1:0] wr_used,
  input  logic                        rclk,
  input  logic                        rd_req,
  output logic [DATA_W-1:0]           rd_data,
  output logic                        rd_full,
  output logic                        rd_empty,
  output logic [ADDR_W+COUNT_MSB-1:0] rd_used
);
  localparam int CW      = ADDR_W + int'(COUNT_MSB);
  localparam int W2R_STG = xfifo_pkg::sync_stages(WR2RD_SYNC, CLOCKS_RELATED);
  localparam int R2W_STG = xfifo_pkg::sync_stages(RD2WR_SYNC, CLOCKS_RELATED);

  // named internal events, brought out for the checker
  logic              wrst, rrst;
  logic              wr_step, rd_step;
  logic [ADDR_W:0]   wgray, rgray, wgray_r, rgray_w;
  logic [ADDR_W:0]   wused_raw, rused_raw;
  logic [ADDR_W-1:0] waddr, raddr;

  xfifo_rst_sync #(.ENABLE(WR_CLR_SYNC), .LEN(2)) u_wrst (
    .clk(wclk), .clr(clr), .rst(wrst));
  xfifo_rst_sync #(.ENABLE(RD_CLR_SYNC), .LEN(2)) u_rrst (
    .clk(rclk), .clr(clr), .rst(rrst));

  xfifo_sync #(.W(ADDR_W+1), .STAGES(W2R_STG)) u_w2r (
    .clk(rclk), .rst(rrst), .d(wgray), .q(wgray_r));
  xfifo_sync #(.W(ADDR_W+1), .STAGES(R2W_STG)) u_r2w (
    .clk(wclk), .rst(wrst), .d(rgray), .q(rgray_w));

  xfifo_port_ctl #(.AW(ADDR_W), .CW(CW), .CNT_DLY(WR_CNT_DLY), .PRODUCER(1'b1)) u_wctl (
    .clk(wclk), .rst(wrst), .req(wr_req), .far_gray(rgray_w),
    .near_gray(wgray), .addr(waddr), .step(wr_step),
    .full(wr_full), .empty(wr_empty), .used_raw(wused_raw), .used(wr_used));

  xfifo_port_ctl #(.AW(ADDR_W), .CW(CW), .CNT_DLY(RD_CNT_DLY), .PRODUCER(1'b0)) u_rctl (
    .clk(rclk), .rst(rrst), .req(rd_req), .far_gray(wgray_r),
    .near_gray(rgray), .addr(raddr), .step(rd_step),
    .full(rd_full), .empty(rd_empty), .used_raw(rused_raw), .used(rd_used));

  xfifo_ram #(.DW(DATA_W), .AW(ADDR_W)) u_ram (
    .wclk(wclk), .we(wr_step), .waddr(waddr), .wdata(wr_data),
    .rclk(rclk), .rrst(rrst), .re(rd_step), .raddr(raddr), .rdata(rd_data));
endmodule

// File: rtl/xfifo_dc_chk.sv
module xfifo_dc_chk #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input logic          wclk,
  input logic          rclk,
  input logic          wrst,
  input logic          rrst,
  input logic          wr_full,
  input logic          wr_empty,
  input logic          rd_full,
  input logic          rd_empty,
  input logic [AW:0]   wgray,
  input logic [AW:0]   rgray,
  input logic [AW:0]   wused_raw,
  input logic [AW:0]   rused_raw,
  input logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  p_no_overflow_r2: assert property (@(posedge wclk) disable iff (wrst)
    wr_full |=> $stable(wgray));

  p_no_underflow_r3: assert property (@(posedge rclk) disable iff (rrst)
    rd_empty |=> ($stable(rgray) && $stable(rd_data)));

  p_wflags_excl_r2: assert property (@(posedge wclk) disable iff (wrst)
    !(wr_full && wr_empty));

  p_rflags_excl_r4: assert property (@(posedge rclk) disable iff (rrst)
    !(rd_full && rd_empty));

  p_wgray_step_r5: assert property (@(posedge wclk) disable iff (wrst)
    $countones(wgray ^ $past(wgray)) <= 1);

  p_rgray_step_r5: assert property (@(posedge rclk) disable iff (rrst)
    $countones(rgray ^ $past(rgray)) <= 1);

  p_wcount_bound_r6: assert property (@(posedge wclk) disable iff (wrst)
    wused_raw <= (AW+1)'(DEPTH));

  p_rcount_bound_r6: assert property (@(posedge rclk) disable iff (rrst)
    rused_raw <= (AW+1)'(DEPTH));
endmodule

bind xfifo_dc xfifo_dc_chk #(.AW(ADDR_W), .DW(DATA_W)) u_chk (
  .wclk(wclk), .rclk(rclk), .wrst(wrst), .rrst(rrst),
  .wr_full(wr_full), .wr_empty(wr_empty), .rd_full(rd_full), .rd_empty(rd_empty),
  .wgray(wgray), .rgray(rgray), .wused_raw(wused_raw), .rused_raw(rused_raw),
  .rd_data(rd_data));

// File: tb/sim_xfifo_dc.sv
module sim_xfifo_dc;
  localparam int DW    = 8;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;
  localparam int CW    = AW + 1;

  logic          clr = 1'b1, wclk = 1'b0, rclk = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_req = 1'b0, rd_req = 1'b0;
  logic          wr_full, wr_empty, rd_full, rd_empty;
  logic [CW-1:0] wr_used, rd_used;
  logic [DW-1:0] rd_data;

  int n_chk = 0, n_err = 0;
  logic [DW-1:0] exp_q [$];

  always #2.5 wclk = ~wclk;   // 200 MHz write clock
  always #3.5 rclk = ~rclk;

  xfifo_dc u0 (
    .clr(clr), .wclk(wclk), .wr_data(wr_data), .wr_req(wr_req),
    .wr_full(wr_full), .wr_empty(wr_empty), .wr_used(wr_used),
    .rclk(rclk), .rd_req(rd_req), .rd_data(rd_data),
    .rd_full(rd_full), .rd_empty(rd_empty), .rd_used(rd_used));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // driver: write one word, pushing it to the scoreboard only when accepted
  task automatic push_word(input logic [DW-1:0] d);
    @(negedge wclk);
    while (wr_full) @(negedge wclk);
    wr_req  = 1'b1;
    wr_data = d;
    exp_q.push_back(d);
    @(negedge wclk);
    wr_req = 1'b0;
  endtask

  // monitor: read one word and compare with the scoreboard head
  task automatic pop_word(input string tag);
    logic [DW-1:0] e;
    @(negedge rclk);
    while (rd_empty) @(negedge rclk);
    rd_req = 1'b1;
    @(negedge rclk);
    rd_req = 1'b0;
    e = (exp_q.size() > 0) ? exp_q.pop_front() : '0;
    check(tag, 32'(rd_data), 32'(e));
  endtask

  initial begin
    #2000000;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [DW-1:0] held;
    int n;
    repeat (4) @(negedge wclk);
    clr = 1'b0;
    repeat (6) @(negedge wclk);
    repeat (2) @(negedge rclk);
    // R8 reset state
    check("R8 wr_empty", 32'(wr_empty), 1);
    check("R8 rd_empty", 32'(rd_empty), 1);
    check("R8 wr_full", 32'(wr_full), 0);
    check("R8 rd_full", 32'(rd_full), 0);
    check("R8 wr_used", 32'(wr_used), 0);
    check("R8 rd_used", 32'(rd_used), 0);

    // R6 count delay and R5 crossing latency on a first write
    push_word(8'h5A);
    check("R6 wr_used before delay", 32'(wr_used), 0);
    check("R5 rd_empty not yet", 32'(rd_empty), 1);
    n = 0;
    while (rd_empty && n < 10) begin @(negedge rclk); n++; end
    check("R5 crossing within 3 rclk", 32'(n <= 3 && n >= 1), 1);
    @(negedge wclk);
    check("R6 wr_used after delay", 32'(wr_used), 1);
    pop_word("R1 single word");

    // R2 fill to full, R7 full count
    for (int i = 0; i < DEPTH; i++) push_word(8'(8'h10 + i));
    check("R2 wr_full at depth", 32'(wr_full), 1);
    @(negedge wclk);
    check("R7 wr_used full", 32'(wr_used), DEPTH);
    wr_req = 1'b1; wr_data = 8'hEE;   // dropped writes
    repeat (3) @(negedge wclk);
    wr_req = 1'b0;
    repeat (8) @(negedge rclk);
    check("R4 rd_full delayed", 32'(rd_full), 1);
    check("R7 rd_used full", 32'(rd_used), DEPTH);
    check("R2 wr_used unchanged", 32'(wr_used), DEPTH);

    // R1 drain in order; R4 wr_empty lags
    for (int i = 0; i < DEPTH; i++) pop_word("R1 drain order");
    check("R4 wr_empty still low", 32'(wr_empty), 0);
    check("R2 no extra word", 32'(rd_empty), 1);

    // R3 underflow
    held = rd_data;
    rd_req = 1'b1;
    repeat (3) @(negedge rclk);
    rd_req = 1'b0;
    @(negedge rclk);
    check("R3 rd_data held", 32'(rd_data), 32'(held));
    check("R3 rd_used zero", 32'(rd_used), 0);
    repeat (8) @(negedge wclk);
    check("R4 wr_empty after sync", 32'(wr_empty), 1);
    push_word(8'hC3);
    pop_word("R3 pointer intact");

    // R8 clear with words in flight
    for (int i = 0; i < 5; i++) push_word(8'(8'h70 + i));
    @(negedge wclk);
    clr = 1'b1;
    repeat (3) @(negedge wclk);
    clr = 1'b0;
    exp_q.delete();
    repeat (6) @(negedge wclk);
    repeat (4) @(negedge rclk);
    check("R8 rd_empty after clear", 32'(rd_empty), 1);
    check("R8 wr_empty after clear", 32'(wr_empty), 1);
    check("R8 wr_used after clear", 32'(wr_used), 0);
    check("R8 rd_used after clear", 32'(rd_used), 0);
    check("R8 rd_data after clear", 32'(rd_data), 0);
    for (int i = 0; i < 3; i++) push_word(8'(8'hA0 + i));
    for (int i = 0; i < 3; i++) pop_word("R8 reuse after clear");

    // R1 streaming with gaps on both sides
    fork
      begin
        for (int i = 0; i < 300; i++) begin
          push_word(8'(i * 7 + 3));
          repeat ($urandom_range(0, 2)) @(negedge wclk);
        end
      end
      begin
        for (int i = 0; i < 300; i++) begin
          pop_word("R1 stream order");
          repeat ($urandom_range(0, 3)) @(negedge rclk);
        end
      end
    join

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule